// File: doc/BRIEF.md
# Elementary Cellular Automaton Row Generator

This block evolves a one-dimensional, two-state cellular automaton over a row of `CELLS` cells held in registers. Each step computes a whole new generation in parallel and presents it on `row_bits` with a one-cycle `row_valid` strobe and a row index, ready to be written into a display frame buffer by a downstream writer. A page holds `ROWS` rows: row 0 is the starting row, and rows 1 to `ROWS-1` are successive generations. After the last row the block idles until a page request arrives. The next page then starts from the last generation of the page just finished, so the pattern carries on without a break.

The starting row of the first page after reset is either a single live cell near the middle or a pseudo-random row. The random row is drawn from a 31-bit shift register that is seeded from a free-running cycle counter, so each reset gives a different pattern. The cells past the ends of the row read either as dead or as the cell at the opposite end. The rule, the starting-row choice and the edge choice are captured only while reset is held.

Top module: `ca_row_gen`

## Requirements
- R1: Each new cell equals bit N of the captured 8-bit rule. N is (left neighbour)*4 + (cell)*2 + (right neighbour), taken from the previous row. Cell i's left neighbour is cell i-1 and its right neighbour is cell i+1, where cell i is `row_bits[i]`.
- R2: With `wrap_mode` captured as 0, the neighbour to the left of cell 0 and the neighbour to the right of cell CELLS-1 both read as 0.
- R3: With `wrap_mode` captured as 1, cell 0's left neighbour is cell CELLS-1 and cell CELLS-1's right neighbour is cell 0.
- R4: With `rand_mode` captured as 0, row 0 of the first page after reset has only cell CELLS/2 set.
- R5: With `rand_mode` captured as 1, row 0 of the first page after reset is filled from a 31-bit shift register. On the last clock edge that has reset high, the register loads the free-running counter value with bit 0 forced to 1. The counter is 0 at time zero and adds 1 on every edge. Cell i takes the register's bit 30 after i shifts, and each shift moves bits up by one and inserts bit 27 XOR bit 30 at bit 0.
- R6: Row 0 appears on the first clock edge after reset is released. Each further row follows on the next edge, so `row_valid` is high for one cycle per row, and `row_idx` counts up from 0 to ROWS-1.
- R7: After row ROWS-1, `row_valid` stays low until a page request is accepted.
- R8: If `page_req` is high on an edge while the block is idle, a new page starts. Its row 0 appears on the following edge, equal to the last row of the previous page, and evolution continues from it.
- R9: A `page_req` that arrives while a page is still being produced has no effect.
- R10: Changes to `rule_in`, `rand_mode` and `wrap_mode` while reset is low have no effect until the next reset.
- R11: Reset overrides every other input. On the edge after reset is sampled high, `row_valid` is 0, `row_idx` is 0 and `row_bits` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; settings are captured while high |
| rule_in | input | 8 | Evolution rule |
| rand_mode | input | 1 | Starting row: 0 single centre cell, 1 pseudo-random |
| wrap_mode | input | 1 | Edges: 0 dead cells beyond the ends, 1 wraparound |
| page_req | input | 1 | Request the next page while idle |
| row_bits | output | CELLS | Current generation, cell i on bit i |
| row_valid | output | 1 | High for one cycle per emitted row |
| row_idx | output | RIDX_W | Row number within the page, from 0 |

## Verification
Every output comes from a single register stage. Row 0 is therefore due one edge after reset is released, and one edge after an accepted page request. Each later row is due exactly one edge after the row before it, and `row_valid` is due low one edge after the last row. The bench changes inputs on falling edges and samples outputs on the falling edge that follows each rising edge, so each check reads the value that one specific edge produced. The bench computes the random seed from its own count of edges, which starts at the same time-zero value as the design's counter.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam int LFSR_W   = 31;
  localparam int TAP_HI   = 30;
  localparam int TAP_LO   = 27;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } ca_state_e;
endpackage

// File: rtl/ca_next_row.sv
module ca_next_row #(
  parameter int CELLS = 16
) (
  input  logic [CELLS-1:0] cur,
  input  logic [7:0]       rule,
  input  logic             wrap,
  output logic [CELLS-1:0] nxt
);
  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic lft, rgt;
    if (i == 0) begin : g_left_edge
      assign lft = wrap & cur[CELLS-1];
    end else begin : g_left_in
      assign lft = cur[i-1];
    end
    if (i == CELLS-1) begin : g_right_edge
      assign rgt = wrap & cur[0];
    end else begin : g_right_in
      assign rgt = cur[i+1];
    end
    assign nxt[i] = rule[{lft, cur[i], rgt}];
  end
endmodule

// File: rtl/ca_rand_fill.sv
module ca_rand_fill
  import ca_pkg::*;
#(
  parameter int CELLS = 16
) (
  input  logic [LFSR_W-1:0] seed,
  output logic [CELLS-1:0]  bits,
  output logic [LFSR_W-1:0] seed_next
);
  logic [LFSR_W-1:0] chain [CELLS+1];

  assign chain[0] = seed;
  for (genvar i = 0; i < CELLS; i++) begin : g_step
    assign bits[i]      = chain[i][TAP_HI];
    assign chain[i+1]   = {chain[i][LFSR_W-2:0], chain[i][TAP_LO] ^ chain[i][TAP_HI]};
  end
  assign seed_next = chain[CELLS];
endmodule

// File: rtl/ca_row_gen.sv
module ca_row_gen
  import ca_pkg::*;
#(
  parameter  int CELLS  = 16,
  parameter  int ROWS   = 6,
  localparam int RIDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rule_in,
  input  logic              rand_mode,
  input  logic              wrap_mode,
  input  logic              page_req,
  output logic [CELLS-1:0]  row_bits,
  output logic              row_valid,
  output logic [RIDX_W-1:0] row_idx
);
  localparam int                CENTER   = CELLS / 2;
  localparam logic [CELLS-1:0]  SEED_ROW = CELLS'(1) << CENTER;
  localparam logic [RIDX_W-1:0] LAST_IDX = RIDX_W'(ROWS - 1);

  logic [LFSR_W-1:0] free_cnt = '0;
  logic [LFSR_W-1:0] lfsr_q;
  logic [7:0]        rule_q;
  logic              rand_q, wrap_q, cont_q;
  ca_state_e         state_q;
  logic [CELLS-1:0]  row_q;
  logic              valid_q;
  logic [RIDX_W-1:0] idx_q;

  logic [CELLS-1:0]  evolved, rand_row;
  logic [LFSR_W-1:0] lfsr_adv;

  ca_next_row #(.CELLS(CELLS)) u_next (
    .cur  (row_q),
    .rule (rule_q),
    .wrap (wrap_q),
    .nxt  (evolved)
  );

  ca_rand_fill #(.CELLS(CELLS)) u_rand (
    .seed      (lfsr_q),
    .bits      (rand_row),
    .seed_next (lfsr_adv)
  );

  always_ff @(posedge clk) begin
    free_cnt <= free_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rule_q  <= rule_in;
      rand_q  <= rand_mode;
      wrap_q  <= wrap_mode;
      lfsr_q  <= {free_cnt[LFSR_W-1:1], 1'b1};
      cont_q  <= 1'b0;
      state_q <= ST_INIT;
      row_q   <= '0;
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_INIT: begin
          valid_q <= 1'b1;
          idx_q   <= '0;
          if (!cont_q) begin
            if (rand_q) begin
              row_q  <= rand_row;
              lfsr_q <= lfsr_adv;
            end else begin
              row_q  <= SEED_ROW;
            end
          end
          state_q <= (ROWS == 1) ? ST_WAIT : ST_RUN;
        end
        ST_RUN: begin
          valid_q <= 1'b1;
          row_q   <= evolved;
          idx_q   <= idx_q + 1'b1;
          if (idx_q + 1'b1 == LAST_IDX) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          valid_q <= 1'b0;
          if (page_req) begin
            cont_q  <= 1'b1;
            state_q <= ST_INIT;
          end
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  assign row_bits  = row_q;
  assign row_valid = valid_q;
  assign row_idx   = idx_q;
endmodule

// File: rtl/ca_row_gen_chk.sv
module ca_row_gen_chk #(
  parameter int ROWS   = 6,
  parameter int RIDX_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              row_valid,
  input logic [RIDX_W-1:0] row_idx,
  input logic [7:0]        rule_q,
  input logic              rand_q,
  input logic              wrap_q
);
  localparam logic [RIDX_W-1:0] LAST = RIDX_W'(ROWS - 1);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!row_valid && row_idx == '0)); // R11

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
    (row_valid && row_idx != LAST) |=> (row_valid && row_idx == RIDX_W'($past(row_idx) + 1'b1))); // R6

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    row_valid |-> (row_idx <= LAST)); // R6

  AST_PAGE_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(row_valid) |-> (row_idx == '0)); // R8

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (row_valid && row_idx == LAST) |=> !row_valid); // R7

  AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(rule_q) && $stable(rand_q) && $stable(wrap_q))); // R10
endmodule

bind ca_row_gen ca_row_gen_chk #(.ROWS(ROWS), .RIDX_W(RIDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .row_valid (row_valid),
  .row_idx   (row_idx),
  .rule_q    (rule_q),
  .rand_q    (rand_q),
  .wrap_q    (wrap_q)
);

// File: tb/tb_ca_row_gen.sv
module tb_ca_row_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CELLS  = 16;
  localparam int ROWS   = 6;
  localparam int RIDX_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] rule_in = 8'd0;
  logic rand_mode = 1'b0, wrap_mode = 1'b0, page_req = 1'b0;
  logic [CELLS-1:0]  row_bits;
  logic              row_valid;
  logic [RIDX_W-1:0] row_idx;

  int n_checks = 0, n_fail = 0;
  logic [30:0] edges = '0;
  logic [30:0] seed_cnt;
  logic [CELLS-1:0] model;
  logic [7:0] m_rule;
  logic m_wrap;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edges <= edges + 1'b1;

  ca_row_gen #(.CELLS(CELLS), .ROWS(ROWS)) dut (
    .clk(clk), .rst(rst), .rule_in(rule_in), .rand_mode(rand_mode),
    .wrap_mode(wrap_mode), .page_req(page_req),
    .row_bits(row_bits), .row_valid(row_valid), .row_idx(row_idx)
  );

  function automatic logic [CELLS-1:0] step_row(logic [CELLS-1:0] r, logic [7:0] rl, logic w);
    logic [CELLS-1:0] o;
    for (int i = 0; i < CELLS; i++) begin
      logic l, c, rr;
      l  = (i == 0) ? (w & r[CELLS-1]) : r[i-1];
      rr = (i == CELLS-1) ? (w & r[0]) : r[i+1];
      c  = r[i];
      o[i] = rl[l*4 + c*2 + rr];
    end
    return o;
  endfunction

  function automatic logic [CELLS-1:0] rand_fill(logic [30:0] s);
    logic [CELLS-1:0] o;
    for (int i = 0; i < CELLS; i++) begin
      o[i] = s[30];
      s = {s[29:0], s[27] ^ s[30]};
    end
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [7:0] rl, input logic rm, input logic wm, input int hold);
    @(negedge clk);
    rst = 1'b1; rule_in = rl; rand_mode = rm; wrap_mode = wm; page_req = 1'b0;
    repeat (hold) @(negedge clk);
    chk(!row_valid && row_idx == 0 && row_bits == 0, "R11 reset state",
        {row_valid, 3'b0, row_idx, row_bits}, 0);
    seed_cnt = edges;
    @(negedge clk);
    rst = 1'b0;
    m_rule = rl; m_wrap = wm;
    model = rm ? rand_fill({seed_cnt[30:1], 1'b1}) : (CELLS'(1) << (CELLS/2));
  endtask

  task automatic take_page(input string req, input int poke_at);
    for (int i = 0; i < ROWS; i++) begin
      @(negedge clk);
      page_req = (i == poke_at);
      if (i > 0) model = step_row(model, m_rule, m_wrap);
      chk(row_valid && row_idx == RIDX_W'(i), "R6 valid/index", {row_valid, row_idx}, {1'b1, RIDX_W'(i)});
      chk(row_bits == model, req, row_bits, model);
    end
    @(negedge clk);
    page_req = 1'b0;
    chk(!row_valid, "R7 idle after last row", row_valid, 0);
  endtask

  task automatic next_page(input string req);
    page_req = 1'b1;
    @(negedge clk);
    page_req = 1'b0;
    for (int i = 0; i < ROWS; i++) begin
      @(negedge clk);
      if (i > 0) model = step_row(model, m_rule, m_wrap);
      chk(row_valid && row_idx == RIDX_W'(i), "R8 valid/index", {row_valid, row_idx}, {1'b1, RIDX_W'(i)});
      chk(row_bits == model, req, row_bits, model);
    end
    @(negedge clk);
    chk(!row_valid, "R7 idle after continued page", row_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R1 R2 R3 R4: every rule, both edge modes, seed start
    for (int w = 0; w < 2; w++)
      for (int r = 0; r < 256; r++) begin
        do_reset(8'(r), 1'b0, w[0], 2);
        take_page(w ? "R3 R1 wrap seed rows" : "R2 R1 zero seed rows", -1);
      end
    // R4 explicit seed shape
    do_reset(8'd204, 1'b0, 1'b0, 3);
    @(negedge clk);
    chk(row_bits == (CELLS'(1) << (CELLS/2)), "R4 seed row", row_bits, CELLS'(1) << (CELLS/2));
    // R8 R2: shifting rule drains through zero edge across pages
    do_reset(8'd170, 1'b0, 1'b0, 2);
    take_page("R2 shift page", -1);
    for (int p = 0; p < 3; p++) next_page("R8 R2 continued page");
    // R8 R3: shifting rule wraps around
    do_reset(8'd170, 1'b0, 1'b1, 2);
    take_page("R3 shift page", -1);
    for (int p = 0; p < 3; p++) next_page("R8 R3 continued page");
    // R9: request mid-page ignored, no new rows while idle
    do_reset(8'd30, 1'b0, 1'b1, 2);
    take_page("R9 page with early request", 2);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!row_valid, "R9 early request ignored", row_valid, 0);
    end
    next_page("R9 later request accepted");
    // R10: settings changed without reset are ignored
    do_reset(8'd110, 1'b0, 1'b1, 2);
    take_page("R10 first page", -1);
    rule_in = 8'd85; wrap_mode = 1'b0; rand_mode = 1'b1;
    next_page("R10 settings held");
    // R5: random start for several reset lengths
    for (int h = 1; h < 9; h++) begin
      do_reset(h[0] ? 8'd30 : 8'd90, 1'b1, h[1], h + 3);
      take_page("R5 random page", -1);
    end
    // R11: reset mid-page wins over generation and request
    do_reset(8'd150, 1'b0, 1'b0, 2);
    @(negedge clk); @(negedge clk);
    rst = 1'b1; page_req = 1'b1;
    @(negedge clk);
    chk(!row_valid && row_idx == 0 && row_bits == 0, "R11 reset mid-page",
        {row_valid, 3'b0, row_idx, row_bits}, 0);
    page_req = 1'b0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule